// File: doc/BRIEF.md
# Per-Character Blink Timing Generator

This block sets the rhythm for blinking characters in an on-screen text overlay. It counts video fields, one pulse per vertical sync. From a period select and a duty select it produces a strobe that is high during the visible part of each blink cycle and low during the dark part. A per-character gate combines the strobe with the blink attribute of the character currently being drawn. Characters that carry the attribute disappear while the strobe is low. All other characters are never blanked.

Two cycle lengths are offered, counted in fields: a short one of about half a second and a long one of about a second. There are three on-time ratios and one code that turns blinking off. While blinking runs, a new setting waits for the end of the running cycle, so a cycle is never cut short. While blinking is off, a new setting starts at the next field. Hardware reset clears both selects, so blinking is off after reset.

Top module: `blink_timing_gen`

## Requirements
- R1: After reset the active period is short, the active duty code is 00, and `blink_on` and `char_visible` are both 1.
- R2: While the active duty code is 00, `blink_on` stays 1 on every field.
- R3: A blink cycle lasts SHORT_FIELDS field pulses (default 32) when the active period bit is 0, and LONG_FIELDS (default 64) when it is 1.
- R4: Field positions are numbered from 0 within the cycle. `blink_on` is 1 for the first N/4·k positions and 0 for the rest, where N is the cycle length and k is the duty code. Code 01 gives 25%, 10 gives 50% and 11 gives 75%.
- R5: While the active duty code is not 00, a change on `period_sel` or `duty_sel` takes effect only at the field pulse that ends the current cycle. That pulse starts a new cycle at position 0 with the new setting.
- R6: While the active duty code is 00, each field pulse loads `period_sel` and `duty_sel`, and that field becomes position 0 of a new cycle.
- R7: `char_visible` equals `blink_on OR NOT char_blink`. A character with `char_blink` = 0 is always visible.
- R8: Without a field pulse the position and the active setting do not change, so `blink_on` holds its value whatever the selects do.
- R9: `blink_on` reflects a field pulse in the first clock cycle after the edge that samples the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_pulse | input | 1 | One-cycle pulse per video field |
| period_sel | input | 1 | 0 = short cycle, 1 = long cycle |
| duty_sel | input | 2 | 00 off, 01 25%, 10 50%, 11 75% |
| char_blink | input | 1 | Blink attribute of the current character |
| blink_on | output | 1 | Blink strobe, low in the dark part of the cycle |
| char_visible | output | 1 | Gate for the current character's pixels |

## Verification
The state lives in a field position counter and an active setting register. An off-by-one in the cycle length shows within one cycle: the first visible field comes one pulse too early or too late. A wrong on/off threshold shows at the first dark field. A setting that loads at the wrong moment changes the strobe pattern within the running cycle. The bench therefore compares `blink_on` and `char_visible` after every field pulse over several complete cycles of each period, with settings changed in the middle of a cycle and while blinking is off.

// File: rtl/blink_pkg.sv
package blink_pkg;

    typedef enum logic [1:0] {
        DUTY_OFF = 2'b00,
        DUTY_25  = 2'b01,
        DUTY_50  = 2'b10,
        DUTY_75  = 2'b11
    } duty_e;

    typedef struct packed {
        logic  period;
        duty_e duty;
    } blink_cfg_t;

    localparam blink_cfg_t CFG_RESET = '{period: 1'b0, duty: DUTY_OFF};

endpackage

// File: rtl/blink_cfg_latch.sv
module blink_cfg_latch
    import blink_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       period_in,
    input  logic [1:0] duty_in,
    output blink_cfg_t cfg
);

    typedef struct packed {
        blink_cfg_t cfg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cfg.period = period_in;
            st_d.cfg.duty   = duty_e'(duty_in);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cfg: CFG_RESET};
        else        st_q <= st_d;
    end

    assign cfg = st_q.cfg;

    // R5: the active setting moves only on a boundary load
    a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st_q.cfg));

endmodule

// File: rtl/blink_field_counter.sv
module blink_field_counter
    import blink_pkg::*;
#(
    parameter int SHORT_FIELDS = 32,
    parameter int LONG_FIELDS  = 64,
    localparam int CW = $clog2(LONG_FIELDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          field_pulse,
    input  blink_cfg_t    cfg,
    output logic [CW-1:0] pos,
    output logic [CW:0]   cycle_len,
    output logic          boundary
);

    localparam logic [CW:0] LEN_SHORT = (CW+1)'(SHORT_FIELDS);
    localparam logic [CW:0] LEN_LONG  = (CW+1)'(LONG_FIELDS);

    typedef struct packed {
        logic [CW-1:0] pos;
    } state_t;

    state_t st_d, st_q;
    logic   at_last;
    logic   idle;

    always_comb begin
        cycle_len = cfg.period ? LEN_LONG : LEN_SHORT;
        at_last   = ({1'b0, st_q.pos} == (cycle_len - (CW+1)'(1)));
        idle      = (cfg.duty == DUTY_OFF);
        boundary  = field_pulse && (idle || at_last);
        st_d      = st_q;
        if (field_pulse) begin
            if (idle || at_last) st_d.pos = '0;
            else                 st_d.pos = st_q.pos + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{pos: '0};
        else        st_q <= st_d;
    end

    assign pos = st_q.pos;

    // R3: the position never reaches the active cycle length
    a_r3_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, st_q.pos} < cycle_len));

    // R8: the position moves only on a field pulse
    a_r8_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !field_pulse |=> $stable(st_q.pos));

    // R6: a pulse while blinking is off restarts at position 0
    a_r6_idle_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (field_pulse && cfg.duty == DUTY_OFF) |=> (st_q.pos == '0));

endmodule

// File: rtl/blink_duty_compare.sv
module blink_duty_compare
    import blink_pkg::*;
#(
    parameter int LONG_FIELDS = 64,
    localparam int CW = $clog2(LONG_FIELDS)
) (
    input  blink_cfg_t    cfg,
    input  logic [CW-1:0] pos,
    input  logic [CW:0]   cycle_len,
    output logic          strobe
);

    logic [CW+1:0] quarter;
    logic [CW+1:0] on_limit;

    always_comb begin
        quarter  = {2'b00, cycle_len[CW:2]} >> 0;
        on_limit = quarter * (CW+2)'(cfg.duty);
        if (cfg.duty == DUTY_OFF) strobe = 1'b1;
        else                      strobe = ({2'b00, pos} < on_limit);
    end

endmodule

// File: rtl/blink_timing_gen.sv
module blink_timing_gen
    import blink_pkg::*;
#(
    parameter int SHORT_FIELDS = 32,
    parameter int LONG_FIELDS  = 64,
    localparam int CW = $clog2(LONG_FIELDS)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       field_pulse,
    input  logic       period_sel,
    input  logic [1:0] duty_sel,
    input  logic       char_blink,
    output logic       blink_on,
    output logic       char_visible
);

    blink_cfg_t    cfg;
    logic [CW-1:0] pos;
    logic [CW:0]   cycle_len;
    logic          boundary;
    logic          strobe;

    blink_cfg_latch u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (boundary),
        .period_in (period_sel),
        .duty_in   (duty_sel),
        .cfg       (cfg)
    );

    blink_field_counter #(
        .SHORT_FIELDS (SHORT_FIELDS),
        .LONG_FIELDS  (LONG_FIELDS)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .field_pulse (field_pulse),
        .cfg         (cfg),
        .pos         (pos),
        .cycle_len   (cycle_len),
        .boundary    (boundary)
    );

    blink_duty_compare #(
        .LONG_FIELDS (LONG_FIELDS)
    ) u_cmp (
        .cfg       (cfg),
        .pos       (pos),
        .cycle_len (cycle_len),
        .strobe    (strobe)
    );

    assign blink_on     = strobe;
    assign char_visible = strobe | ~char_blink;

    // R4: position 0 of every cycle is visible
    a_r4_first_field_on: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == '0) |-> blink_on);

    // R7: characters without the attribute are never blanked
    a_r7_plain_visible: assert property (@(posedge clk) disable iff (!rst_n)
        !char_blink |-> char_visible);

    // R2: with blinking off the strobe stays high
    a_r2_off_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.duty == DUTY_OFF) |-> blink_on);

endmodule

// File: tb/tb_blink_timing_gen.sv
module tb_blink_timing_gen;

    localparam int SHORT_N = 32;
    localparam int LONG_N  = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       field_pulse = 1'b0;
    logic       period_sel = 1'b0;
    logic [1:0] duty_sel = 2'b00;
    logic       char_blink = 1'b1;
    logic       blink_on;
    logic       char_visible;

    always #10 clk = ~clk;

    blink_timing_gen #(.SHORT_FIELDS(SHORT_N), .LONG_FIELDS(LONG_N)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .field_pulse  (field_pulse),
        .period_sel   (period_sel),
        .duty_sel     (duty_sel),
        .char_blink   (char_blink),
        .blink_on     (blink_on),
        .char_visible (char_visible)
    );

    typedef struct {
        bit    on;
        bit    vis;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    // reference state built from the requirements
    bit       m_per;
    bit [1:0] m_duty;
    int       m_pos;

    function automatic int m_len();
        return m_per ? LONG_N : SHORT_N;
    endfunction

    function automatic bit m_on();
        if (m_duty == 2'b00) return 1'b1;
        return m_pos < (m_len() / 4) * int'(m_duty);
    endfunction

    task automatic push(string req);
        exp_t e;
        e.on  = m_on();
        e.vis = m_on() | ~char_blink;
        e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic pulse(string req);
        @(negedge clk) field_pulse = 1'b1;
        @(negedge clk) field_pulse = 1'b0;
        if (m_duty == 2'b00 || m_pos == m_len() - 1) begin
            m_pos  = 0;
            m_per  = period_sel;
            m_duty = duty_sel;
        end else begin
            m_pos++;
        end
        push(req);
    endtask

    task automatic pulses(int n, string req);
        for (int i = 0; i < n; i++) pulse(req);
    endtask

    task automatic do_reset(string req);
        wait (exp_q.size() == 0);
        @(negedge clk) rst_n = 1'b0;
        m_per = 0; m_duty = 0; m_pos = 0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
        push(req);
    endtask

    // monitor: pops each expected item and compares at the ports
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                total++;
                if (blink_on !== e.on) begin
                    bad++;
                    $display("FAIL %s blink_on actual=%0b expected=%0b", e.req, blink_on, e.on);
                end
                total++;
                if (char_visible !== e.vis) begin
                    bad++;
                    $display("FAIL %s char_visible actual=%0b expected=%0b", e.req, char_visible, e.vis);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset("R1 reset state");
        pulses(3, "R2 off keeps strobe high");

        // R6: loads at the next pulse while off; R3/R4 short cycle at 25%
        @(negedge clk) begin duty_sel = 2'b01; period_sel = 1'b0; end
        pulses(SHORT_N + 4, "R6 R4 R3 short 25pct");

        // R5: change mid cycle waits for the boundary
        @(negedge clk) duty_sel = 2'b11;
        push("R8 select change without pulse");
        pulses(SHORT_N + 6, "R5 R4 switch to 75pct");

        // R3 long cycle at 50%
        @(negedge clk) begin duty_sel = 2'b10; period_sel = 1'b1; end
        pulses(LONG_N + 40, "R3 R4 long 50pct");

        // R7 attribute gating while dark and while lit
        @(negedge clk) char_blink = 1'b0;
        push("R7 no attribute");
        pulses(LONG_N / 2, "R7 no attribute over cycle");
        @(negedge clk) char_blink = 1'b1;
        push("R7 attribute back");

        // R8 no pulse: selects toggle, outputs must hold
        for (int i = 0; i < 6; i++) begin
            @(negedge clk) begin duty_sel = duty_sel + 2'd1; period_sel = ~period_sel; end
            push("R8 hold without pulse");
        end
        @(negedge clk) begin duty_sel = 2'b00; period_sel = 1'b0; end
        push("R8 hold without pulse");

        // R2 disable taken at boundary, then stays high
        pulses(LONG_N + 8, "R5 R2 disable at boundary");

        // R6 while off, a new long setting starts on the next field
        @(negedge clk) begin duty_sel = 2'b01; period_sel = 1'b1; end
        pulse("R6 R9 start long 25pct");
        pulses(20, "R9 R4 long 25pct");

        // R1 reset mid operation
        do_reset("R1 reset mid cycle");
        pulses(2, "R1 R2 off after reset");

        wait (exp_q.size() == 0);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule